// File: doc/BRIEF.md
# UART Receive Status Tracker

This block is the receive-side register logic of a memory-mapped serial port whose receive path holds one byte. A deserializer offers bytes through a valid/data pair and this block answers with a ready signal. The block stores each accepted byte, keeps a receive level count and derives the full, empty and idle flags from it. Software reaches all of this through a small 32-bit register bus.

Reading the data register removes the byte. The flags return to empty and idle only once the level counter is back at zero. While the single holding slot is occupied, ready drops, so the deserializer has to wait and no byte is lost by overwriting. A sticky watermark interrupt bit is set when an accepted byte takes the level above a programmable threshold. The transmit level arrives from outside and is only reported.

Register bus: `reg_req_i` with `reg_we_i` selects a write or a read, and reads return data combinationally in the same cycle. The word index is `reg_addr_i[5:2]`, and the two low address bits are ignored. The word map is: 0x00 control, 0x04 status, 0x08 receive data, 0x0C level control, 0x10 level status, 0x14 interrupt state.

Top module: `uart_rx_status_top`

## Requirements
- R1: After reset the status word (0x04) reads 0x6, which is full (bit 0) = 0, empty (bit 1) = 1 and idle (bit 2) = 1. Both levels read 0, control reads 0, the interrupt reads 0, `rx_ready_o` is 0 and `irq_rx_wm_o` is 0.
- R2: `rx_ready_o` is high exactly when the receive enable (control bit 0) is 1 and full is 0. A byte offered while ready is low is ignored: the held byte, the level and the flags are unchanged.
- R3: A byte accepted (`rx_valid_i` and `rx_ready_o` high at a clock edge) is stored. Full is set, empty and idle are cleared, and the receive level rises by 1. Full and empty are never both 1.
- R4: A read of 0x08 with receive enabled and a nonzero level returns the held byte in bits 7:0. It lowers the level by 1 and clears full. Empty and idle are set only if the level has become 0.
- R5: A read of 0x08 while the level is 0 or receive is disabled returns the held byte and changes no state.
- R6: The level status word (0x10) carries the registered transmit level in bits 4:0 and the receive level in bits 20:16, each cut to its low 5 bits. The transmit level is sampled from `tx_lvl_i` one cycle earlier and is 0 after reset.
- R7: Writing 0x0C with bit 1 set forces the receive level to 0, and this wins over an accept in the same cycle. The flags and the held byte are still updated as usual, so a byte accepted in that cycle is stored and full stays set.
- R8: Bits 4:2 of 0x0C hold the watermark threshold, which reads back in the same position. The interrupt bit (0x14 bit 0, also `irq_rx_wm_o`) is set on an accept when the previous level plus one exceeds the threshold. The bit stays set until a write to 0x14 with bit 0 set, and a set in the same cycle wins over that clear.
- R9: Control bit 0 reads back as written. Unmapped words (index 6 to 15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Deserializer offers a byte |
| rx_data_i | input | 8 | Offered byte |
| rx_ready_o | output | 1 | Block can take a byte this cycle |
| tx_lvl_i | input | 6 | Transmit level from the transmit path |
| reg_req_i | input | 1 | Register access this cycle |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | 6 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, same cycle |
| irq_rx_wm_o | output | 1 | Watermark interrupt state |

## Verification
The bench offers bytes while the slot is full. A design that overwrote the held byte or kept ready high would return the newer byte and count a level of two. It reads the data register at level zero and with receive disabled, where a faulty design would wrap the counter or set the flags early. It issues a receive reset in the same cycle as an accept, and with a byte held, to catch a design that clears full there or lets the accept raise the level. It also drives transmit levels above 31 and checks the 5-bit fields, together with the watermark set/clear race.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // word indices on the register bus (addr[5:2])
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_RDAT = 2;
  localparam int IDX_FCTL = 3;
  localparam int IDX_FSTA = 4;
  localparam int IDX_INTR = 5;

  localparam int CTRL_EN_BIT    = 0;
  localparam int ST_FULL_BIT    = 0;
  localparam int ST_EMPTY_BIT   = 1;
  localparam int ST_IDLE_BIT    = 2;
  localparam int FCTL_RXRST_BIT = 1;
  localparam int FCTL_WM_LSB    = 2;
  localparam int FSTA_TX_LSB    = 0;
  localparam int FSTA_RX_LSB    = 16;
  localparam int INTR_WM_BIT    = 0;

  typedef struct packed {
    logic ctrl_wr;
    logic fctl_wr;
    logic intr_wr;
    logic rdat_rd;
  } reg_stb_t;
endpackage

// File: rtl/uart_rx_regdec.sv
module uart_rx_regdec
  import uart_rx_pkg::*;
#(
  parameter int IW     = 4,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6,
  parameter int RPT_W  = 5,
  parameter int WM_W   = 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic              en_i,
  input  logic              full_i,
  input  logic              empty_i,
  input  logic              idle_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WM_W-1:0]   wm_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  output reg_stb_t          stb_o,
  output logic [31:0]       rdata_o
);
  logic [RPT_W-1:0] rx_fld, tx_fld;

  // level fields are reported RPT_W wide whatever the counter width
  if (LVL_W >= RPT_W) begin : g_trunc
    assign rx_fld = rx_lvl_i[RPT_W-1:0];
    assign tx_fld = tx_lvl_i[RPT_W-1:0];
    if (LVL_W > RPT_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^{rx_lvl_i[LVL_W-1:RPT_W], tx_lvl_i[LVL_W-1:RPT_W]};
    end
  end else begin : g_ext
    assign rx_fld = RPT_W'(rx_lvl_i);
    assign tx_fld = RPT_W'(tx_lvl_i);
  end

  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    stb_o         = '0;
    stb_o.ctrl_wr = wr && (int'(idx_i) == IDX_CTRL);
    stb_o.fctl_wr = wr && (int'(idx_i) == IDX_FCTL);
    stb_o.intr_wr = wr && (int'(idx_i) == IDX_INTR);
    stb_o.rdat_rd = rd && (int'(idx_i) == IDX_RDAT);
  end

  always_comb begin
    rdata_o = '0;
    case (int'(idx_i))
      IDX_CTRL: rdata_o[CTRL_EN_BIT] = en_i;
      IDX_STAT: begin
        rdata_o[ST_FULL_BIT]  = full_i;
        rdata_o[ST_EMPTY_BIT] = empty_i;
        rdata_o[ST_IDLE_BIT]  = idle_i;
      end
      IDX_RDAT: rdata_o[DATA_W-1:0] = data_i;
      IDX_FCTL: rdata_o[FCTL_WM_LSB +: WM_W] = wm_i;
      IDX_FSTA: begin
        rdata_o[FSTA_TX_LSB +: RPT_W] = tx_fld;
        rdata_o[FSTA_RX_LSB +: RPT_W] = rx_fld;
      end
      IDX_INTR: rdata_o[INTR_WM_BIT] = irq_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              drain_req_i,
  input  logic              rxrst_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              idle_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q, empty_q, idle_q, drain;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] data_q;

  assign ready_o  = en_i & ~full_q;
  assign accept_o = valid_i & ready_o;
  assign drain    = drain_req_i & en_i & (lvl_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      idle_q  <= 1'b1;
      data_q  <= '0;
    end else if (accept_o) begin
      data_q  <= data_i;
      full_q  <= 1'b1;
      empty_q <= 1'b0;
      idle_q  <= 1'b0;
    end else if (drain) begin
      full_q <= 1'b0;
      // flags return only when the counter reaches zero
      if (lvl_q == LVL_W'(1)) begin
        empty_q <= 1'b1;
        idle_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (rxrst_i) begin
      lvl_q <= '0;
    end else begin
      case ({accept_o, drain})
        2'b10:   lvl_q <= lvl_q + LVL_W'(1);
        2'b01:   lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign idle_o  = idle_q;
  assign lvl_o   = lvl_q;
  assign data_o  = data_q;
endmodule

// File: rtl/uart_rx_wm_irq.sv
module uart_rx_wm_irq #(
  parameter int LVL_W = 6,
  parameter int WM_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             wm_wr_i,
  input  logic [WM_W-1:0]  wm_wdata_i,
  input  logic             clr_i,
  output logic [WM_W-1:0]  wm_o,
  output logic             irq_o
);
  logic [WM_W-1:0]  wm_q;
  logic             irq_q, set;
  logic [LVL_W:0]   lvl_nxt;

  assign lvl_nxt = {1'b0, lvl_i} + (LVL_W+1)'(1);
  assign set     = accept_i && (lvl_nxt > (LVL_W+1)'(wm_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wm_wr_i) wm_q <= wm_wdata_i;
      irq_q <= set | (irq_q & ~clr_i);
    end
  end

  assign wm_o  = wm_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_rx_status_top.sv
module uart_rx_status_top
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6,
  parameter int AW     = 6,
  parameter int RPT_W  = 5,
  parameter int WM_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_rx_wm_o
);
  localparam int IW = AW - 2;

  reg_stb_t          stb;
  logic              ctrl_en, rx_full, rx_empty, rx_idle, rx_accept, rx_rst, irq_clr;
  logic [LVL_W-1:0]  rx_lvl, tx_q;
  logic [DATA_W-1:0] rx_hold;
  logic [WM_W-1:0]   wm;
  logic              unused_bits;

  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[31:FCTL_WM_LSB+WM_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en <= 1'b0;
      tx_q    <= '0;
    end else begin
      if (stb.ctrl_wr) ctrl_en <= reg_wdata_i[CTRL_EN_BIT];
      tx_q <= tx_lvl_i;
    end
  end

  assign rx_rst  = stb.fctl_wr & reg_wdata_i[FCTL_RXRST_BIT];
  assign irq_clr = stb.intr_wr & reg_wdata_i[INTR_WM_BIT];

  uart_rx_regdec #(
    .IW(IW), .DATA_W(DATA_W), .LVL_W(LVL_W), .RPT_W(RPT_W), .WM_W(WM_W)
  ) u_dec (
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .idx_i    (reg_addr_i[AW-1:2]),
    .en_i     (ctrl_en),
    .full_i   (rx_full),
    .empty_i  (rx_empty),
    .idle_i   (rx_idle),
    .irq_i    (irq_rx_wm_o),
    .data_i   (rx_hold),
    .wm_i     (wm),
    .rx_lvl_i (rx_lvl),
    .tx_lvl_i (tx_q),
    .stb_o    (stb),
    .rdata_o  (reg_rdata_o)
  );

  uart_rx_hold #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_en),
    .valid_i     (rx_valid_i),
    .data_i      (rx_data_i),
    .drain_req_i (stb.rdat_rd),
    .rxrst_i     (rx_rst),
    .ready_o     (rx_ready_o),
    .accept_o    (rx_accept),
    .full_o      (rx_full),
    .empty_o     (rx_empty),
    .idle_o      (rx_idle),
    .lvl_o       (rx_lvl),
    .data_o      (rx_hold)
  );

  uart_rx_wm_irq #(.LVL_W(LVL_W), .WM_W(WM_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (rx_accept),
    .lvl_i      (rx_lvl),
    .wm_wr_i    (stb.fctl_wr),
    .wm_wdata_i (reg_wdata_i[FCTL_WM_LSB +: WM_W]),
    .clr_i      (irq_clr),
    .wm_o       (wm),
    .irq_o      (irq_rx_wm_o)
  );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk
  import uart_rx_pkg::*;
#(
  parameter int IW     = 4,
  parameter int LVL_W  = 6,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [IW-1:0]     idx_i,
  input logic [1:0]        wlo_i,
  input logic              irq_i,
  input logic              full_i,
  input logic              empty_i,
  input logic              en_i,
  input logic [LVL_W-1:0]  lvl_i,
  input logic [DATA_W-1:0] data_i
);
  logic rd_dat, rxrst, clr, acc;
  assign rd_dat = reg_req_i && !reg_we_i && (int'(idx_i) == IDX_RDAT);
  assign rxrst  = reg_req_i && reg_we_i && (int'(idx_i) == IDX_FCTL) && wlo_i[FCTL_RXRST_BIT];
  assign clr    = reg_req_i && reg_we_i && (int'(idx_i) == IDX_INTR) && wlo_i[INTR_WM_BIT];
  assign acc    = rx_valid_i && rx_ready_o;

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i && rx_valid_i |=> $stable(data_i)); // R2
  AST_ACCEPT_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !rxrst |=> full_i && !empty_i && (lvl_i == LVL_W'($past(lvl_i) + 1'b1))); // R3
  AST_LVL_MAX_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= LVL_W'(1)); // R3
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_i && empty_i)); // R3
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_dat && en_i && (lvl_i != '0) && !rxrst |=> !full_i && (lvl_i == LVL_W'($past(lvl_i) - 1'b1))); // R4
  AST_IDLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_dat && (lvl_i == '0) && !acc |=> $stable(lvl_i) && $stable(full_i) && $stable(data_i)); // R5
  AST_RXRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxrst |=> lvl_i == '0); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !clr |=> irq_i); // R8
endmodule

bind uart_rx_status_top uart_rx_status_chk #(
  .IW(AW-2), .LVL_W(LVL_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .reg_req_i  (reg_req_i),
  .reg_we_i   (reg_we_i),
  .idx_i      (reg_addr_i[AW-1:2]),
  .wlo_i      (reg_wdata_i[1:0]),
  .irq_i      (irq_rx_wm_o),
  .full_i     (rx_full),
  .empty_i    (rx_empty),
  .en_i       (ctrl_en),
  .lvl_i      (rx_lvl),
  .data_i     (rx_hold)
);

// File: tb/tb_uart_rx_status_top.sv
module tb_uart_rx_status_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0, rx_ready_o;
  logic [7:0]  rx_data_i = '0;
  logic [5:0]  tx_lvl_i = '0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        irq_rx_wm_o;

  int total = 0, bad = 0;

  // bench model of the register state
  bit m_en, m_full, m_empty, m_idle, m_irq;
  int m_lvl, m_tx, m_wm;
  logic [7:0] m_data;

  always #(CLK_P/2) clk_i = ~clk_i;

  uart_rx_status_top dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int idx);
    logic [31:0] r = '0;
    case (idx)
      0: r[0] = m_en;
      1: r[2:0] = {m_idle, m_empty, m_full};
      2: r[7:0] = m_data;
      3: r[4:2] = m_wm[2:0];
      4: r = 32'(m_tx & 31) | (32'(m_lvl & 31) << 16);
      5: r[0] = m_irq;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      1: return "R3";
      2: return (m_en && m_lvl > 0) ? "R4" : "R5";
      4: return "R6";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_full = 0; m_empty = 1; m_idle = 1; m_irq = 0;
    m_lvl = 0; m_tx = 0; m_wm = 0; m_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; rx_valid_i = 0; reg_req_i = 0; reg_we_i = 0;
    #1;
    model_reset();
    chk(rx_ready_o == 1'b0, "R1", "ready in reset", 32'(rx_ready_o), 0);
    chk(irq_rx_wm_o == 1'b0, "R1", "irq in reset", 32'(irq_rx_wm_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one bus/stream cycle: drive at negedge, check, advance model
  task automatic cyc(input bit v, input logic [7:0] d, input bit rq, input bit w,
                     input int idx, input logic [31:0] wd, input logic [5:0] tl);
    bit acc, dr, rxr, set, clr;
    @(negedge clk_i);
    rx_valid_i = v; rx_data_i = d; reg_req_i = rq; reg_we_i = w;
    reg_addr_i = {idx[3:0], 2'($urandom % 4)}; reg_wdata_i = wd; tx_lvl_i = tl;
    #1;
    chk(rx_ready_o == (m_en && !m_full), "R2", "ready", 32'(rx_ready_o), 32'(m_en && !m_full));
    chk(irq_rx_wm_o == m_irq, "R8", "irq", 32'(irq_rx_wm_o), 32'(m_irq));
    if (rq && !w)
      chk(reg_rdata_o == exp_rd(idx), tag_of(idx), $sformatf("read idx %0d", idx),
          reg_rdata_o, exp_rd(idx));
    acc = v && m_en && !m_full;
    dr  = rq && !w && idx == 2 && m_en && m_lvl > 0;
    rxr = rq && w && idx == 3 && wd[1];
    clr = rq && w && idx == 5 && wd[0];
    set = acc && (m_lvl + 1) > m_wm;
    m_irq = set || (m_irq && !clr);
    if (rq && w && idx == 3) m_wm = int'(wd[4:2]);
    if (acc) begin
      m_data = d; m_full = 1; m_empty = 0; m_idle = 0;
    end else if (dr) begin
      m_full = 0;
      if (m_lvl == 1) begin m_empty = 1; m_idle = 1; end
    end
    if (rxr) m_lvl = 0;
    else m_lvl = m_lvl + int'(acc) - int'(dr);
    if (rq && w && idx == 0) m_en = wd[0];
    m_tx = int'(tl);
  endtask

  task automatic rd(input int idx);
    cyc(0, 8'h00, 1, 0, idx, 32'h0, 6'd0);
  endtask

  task automatic wr(input int idx, input logic [31:0] wd);
    cyc(0, 8'h00, 1, 1, idx, wd, 6'd0);
  endtask

  initial begin
    #(CLK_P * 190000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2021));
    model_reset();
    do_reset();
    // R1: reset values through the bus
    rd(1); rd(4); rd(0); rd(5); rd(3);
    // R2: byte offered while disabled is ignored
    cyc(1, 8'h11, 0, 0, 0, 0, 0);
    rd(1); rd(2); rd(4);
    // R3: accept
    wr(0, 32'h1);
    cyc(1, 8'hA5, 0, 0, 0, 0, 0);
    rd(1); rd(4);
    // R2 + R4: offer while full, drain in the same cycle
    cyc(1, 8'h3C, 1, 0, 2, 0, 0);
    // R5: read at level zero
    rd(2); rd(1); rd(4);
    // R5: read with receive disabled and a byte held
    cyc(1, 8'h5A, 0, 0, 0, 0, 0);
    wr(0, 32'h0);
    rd(2); rd(4);
    wr(0, 32'h1);
    rd(2); rd(1);
    // R8: watermark 0 sets, clear, then watermark 1 does not set
    wr(3, 32'h0);
    cyc(1, 8'h21, 0, 0, 0, 0, 0);
    rd(5);
    wr(5, 32'h1);
    rd(5); rd(2);
    wr(3, 32'h4);
    rd(3);
    cyc(1, 8'h22, 0, 0, 0, 0, 0);
    rd(5);
    // R8: set and clear together, set wins
    rd(2);
    wr(3, 32'h0);
    cyc(1, 8'h23, 1, 1, 5, 32'h1, 0);
    rd(5);
    // R7: receive reset with byte held, full stays set
    wr(3, 32'h2);
    rd(4); rd(1); rd(2); rd(1);
    // R7: receive reset concurrent with an accept
    do_reset();
    wr(0, 32'h1);
    cyc(1, 8'h77, 1, 1, 3, 32'h2, 0);
    rd(4); rd(1); rd(2); rd(4);
    // R6: transmit level masking
    cyc(0, 0, 0, 0, 0, 0, 6'h3F);
    rd(4);
    cyc(0, 0, 0, 0, 0, 0, 6'h25);
    rd(4);
    // R9: unmapped words
    rd(6); rd(15);
    // random traffic, periodic reset to recover from stuck-full
    for (int i = 0; i < 4000; i++) begin
      int op;
      if (i % 512 == 511) do_reset();
      op = int'($urandom % 8);
      case (op)
        3: cyc(1'($urandom), 8'($urandom), 1, 0, 2, 0, 6'($urandom));
        4: cyc(1'($urandom), 8'($urandom), 1, 0, int'($urandom % 16), 0, 6'($urandom));
        5: cyc(1'($urandom), 8'($urandom), 1, 1, 0, 32'($urandom % 4 != 0), 6'($urandom));
        6: cyc(1'($urandom), 8'($urandom), 1, 1, 3,
               {27'($urandom), 3'($urandom % 3), 1'($urandom % 8 == 0), 1'($urandom)},
               6'($urandom));
        7: cyc(1'($urandom), 8'($urandom), 1, 1, 5, $urandom, 6'($urandom));
        default: cyc(1'($urandom), 8'($urandom), 0, 0, 0, 0, 6'($urandom));
      endcase
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule